// File: doc/BRIEF.md
# Node Input Address to System Address Translator

This block takes an address as seen by one node's memory controller after node interleaving has been stripped, and rebuilds the full 64-bit system address that produced it. It first puts the interleave select bits back: the page-frame part of the input is shifted up by the interleave shift, and this node's select value is placed in the gap just above the 4 KiB page offset. The rebuilt DRAM address is then mapped to the system address space. It either moves back out of the memory hole or adds the node's base address. In the base case the 40-bit result is made canonical by copying bit 39 into bits 63 to 40.

A typical user is error-reporting logic that holds a controller-local address and needs the system address to report. The interleave code, select value, node base and hole registers are static configuration taken from inputs. A request is one cycle with `in_valid` high, and the answer appears one cycle later with `out_valid` high.

Top module: `xlat_rev_addr`

## Requirements
- R1: The interleave shift comes from the 3-bit code `ilv_code`. Code 1 gives shift 1, code 3 gives shift 2 and code 7 gives shift 3. Codes 0, 2, 4, 5 and 6 give shift 0.
- R2: With shift 0 the DRAM address equals `in_addr`, and `ilv_sel` has no effect on the result.
- R3: With shift s > 0 the DRAM address is `in_addr[35:12]` placed at bit 12+s, plus `ilv_sel` placed at bit 12, plus `in_addr[11:0]` unchanged in bits 11 to 0.
- R4: Only the low s bits of `ilv_sel` are inserted. Higher select bits are ignored.
- R5: When `hole_en` is 1 and the DRAM address lies in the hole window, `out_addr` is the zero-extended DRAM address plus `hole_offset`, with no sign extension.
- R6: The hole window is the half-open range from `hole_base` up to, but not including, `hole_base + hole_size`. An address equal to the upper bound, or any address while `hole_en` is 0, takes the base path.
- R7: Outside the hole, bits 39 to 0 of `out_addr` are the low 40 bits of DRAM address plus `node_base`, and bits 63 to 40 all equal bit 39.
- R8: `out_valid` is `in_valid` delayed by one clock. `out_addr` loads only on a cycle with `in_valid` high and otherwise holds.
- R9: While `rst_n` is low, `out_valid` and `out_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 36 | Controller input address |
| ilv_code | input | 3 | Interleave enable code |
| ilv_sel | input | 3 | This node's interleave select value |
| node_base | input | 40 | Node base address |
| hole_en | input | 1 | Hole remap enable |
| hole_base | input | 40 | Lowest DRAM address of the hole window |
| hole_size | input | 40 | Size of the hole window |
| hole_offset | input | 40 | Added to DRAM addresses inside the hole |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 64 | Reconstructed system address |

## Verification
The bench targets every shift code, including the unused codes that must act like shift 0. A decoder that trusted the popcount of the code would scale addresses wrongly for codes 2, 4, 5 and 6. It drives select values wider than the shift, so a missing mask would corrupt the bit above the inserted field. It probes the last address inside the hole and the first address past it. An off-by-one compare would move either address onto the wrong path, and an ignored enable would remap addresses that should use the node base. It checks a base sum whose bit 39 is set, to catch missing sign extension, and a hole sum with bit 39 set, to catch sign extension applied to the hole path. Round trips through a forward model in the bench, both inside the node range and inside the hole, check that the whole chain inverts the forward translation.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   // Width of the interleave enable code and the largest shift it can select.
   localparam int ILV_CODE_W    = 3;
   localparam int ILV_MAX_SHIFT = 3;

   // Shift selected by an interleave code: a code of k low ones means shift k,
   // every other pattern means no interleave.
   function automatic int unsigned ilv_shift_of(input logic [ILV_CODE_W-1:0] code);
      int unsigned s;
      s = 0;
      for (int k = 1; k <= ILV_MAX_SHIFT; k++) begin
         if (code == ILV_CODE_W'((1 << k) - 1)) s = k;
      end
      return s;
   endfunction

endpackage

// File: rtl/xlat_ilv_decode.sv
module xlat_ilv_decode #(
   parameter int CODE_W    = 3,
   parameter int MAX_SHIFT = 3
) (
   input  logic [CODE_W-1:0]  code,
   output logic [MAX_SHIFT:0] shift_oh
);

   logic [MAX_SHIFT:1] hit;

   for (genvar k = 1; k <= MAX_SHIFT; k++) begin : g_code
      localparam logic [CODE_W-1:0] PATTERN = CODE_W'((1 << k) - 1);
      assign hit[k] = (code == PATTERN);
   end

   assign shift_oh[MAX_SHIFT:1] = hit;
   assign shift_oh[0]           = ~|hit;

endmodule

// File: rtl/xlat_ilv_insert.sv
module xlat_ilv_insert #(
   parameter int IN_W      = 36,
   parameter int PHYS_W    = 40,
   parameter int PAGE_LSB  = 12,
   parameter int MAX_SHIFT = 3
) (
   input  logic [IN_W-1:0]      in_addr,
   input  logic [MAX_SHIFT:0]   shift_oh,
   input  logic [MAX_SHIFT-1:0] sel,
   output logic [PHYS_W-1:0]    dram_addr
);

   localparam int HI_W = IN_W - PAGE_LSB;

   logic [HI_W-1:0]     frame;
   logic [PHYS_W-1:0]   page_off;
   logic [PHYS_W-1:0]   cand [MAX_SHIFT+1];

   assign frame    = in_addr[IN_W-1:PAGE_LSB];
   assign page_off = PHYS_W'(in_addr[PAGE_LSB-1:0]);

   // One candidate per shift value; the decoder picks exactly one.
   for (genvar k = 0; k <= MAX_SHIFT; k++) begin : g_shift
      logic [PHYS_W-1:0] moved;
      assign moved = PHYS_W'(frame) << (PAGE_LSB + k);
      if (k == 0) begin : g_none
         assign cand[k] = moved | page_off;
      end else begin : g_sel
         logic [PHYS_W-1:0] sel_field;
         assign sel_field = PHYS_W'(sel[k-1:0]) << PAGE_LSB;
         assign cand[k]   = moved | sel_field | page_off;
      end
   end

   always_comb begin
      dram_addr = '0;
      for (int k = 0; k <= MAX_SHIFT; k++) begin
         if (shift_oh[k]) dram_addr = dram_addr | cand[k];
      end
   end

endmodule

// File: rtl/xlat_hole_window.sv
module xlat_hole_window #(
   parameter int PHYS_W = 40
) (
   input  logic              en,
   input  logic [PHYS_W-1:0] dram_addr,
   input  logic [PHYS_W-1:0] base,
   input  logic [PHYS_W-1:0] size,
   output logic              hit
);

   logic [PHYS_W:0] upper;
   logic            above_lo;
   logic            below_hi;

   assign upper    = {1'b0, base} + {1'b0, size};
   assign above_lo = (dram_addr >= base);
   assign below_hi = ({1'b0, dram_addr} < upper);
   assign hit      = en & above_lo & below_hi;

endmodule

// File: rtl/xlat_sys_compose.sv
module xlat_sys_compose #(
   parameter int PHYS_W = 40,
   parameter int OUT_W  = 64
) (
   input  logic [PHYS_W-1:0] dram_addr,
   input  logic              hole_hit,
   input  logic [PHYS_W-1:0] hole_offset,
   input  logic [PHYS_W-1:0] node_base,
   output logic [OUT_W-1:0]  sys_addr
);

   localparam int EXT_W = OUT_W - PHYS_W;

   logic [OUT_W-1:0]  hole_sum;
   logic [PHYS_W-1:0] base_sum;
   logic [OUT_W-1:0]  base_sys;

   assign hole_sum = OUT_W'(dram_addr) + OUT_W'(hole_offset);
   assign base_sum = dram_addr + node_base;

   if (EXT_W > 0) begin : g_extend
      assign base_sys = {{EXT_W{base_sum[PHYS_W-1]}}, base_sum};
   end else begin : g_flat
      assign base_sys = base_sum;
   end

   assign sys_addr = hole_hit ? hole_sum : base_sys;

endmodule

// File: rtl/xlat_rev_addr.sv
module xlat_rev_addr #(
   parameter int IN_W      = 36,
   parameter int PHYS_W    = 40,
   parameter int OUT_W     = 64,
   parameter int PAGE_LSB  = 12,
   parameter int CODE_W    = xlat_pkg::ILV_CODE_W,
   parameter int MAX_SHIFT = xlat_pkg::ILV_MAX_SHIFT
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [IN_W-1:0]      in_addr,
   input  logic [CODE_W-1:0]    ilv_code,
   input  logic [MAX_SHIFT-1:0] ilv_sel,
   input  logic [PHYS_W-1:0]    node_base,
   input  logic                 hole_en,
   input  logic [PHYS_W-1:0]    hole_base,
   input  logic [PHYS_W-1:0]    hole_size,
   input  logic [PHYS_W-1:0]    hole_offset,
   output logic                 out_valid,
   output logic [OUT_W-1:0]     out_addr
);

   // Elaboration-time parameter checks.
   if (IN_W <= PAGE_LSB) begin : g_bad_in
      $error("xlat_rev_addr: IN_W must exceed PAGE_LSB");
   end
   if (PHYS_W < IN_W + MAX_SHIFT) begin : g_bad_phys
      $error("xlat_rev_addr: PHYS_W too small for the widest interleave");
   end
   if (OUT_W < PHYS_W) begin : g_bad_out
      $error("xlat_rev_addr: OUT_W must not be below PHYS_W");
   end
   if (MAX_SHIFT < 1 || MAX_SHIFT > CODE_W) begin : g_bad_shift
      $error("xlat_rev_addr: MAX_SHIFT must lie in 1..CODE_W");
   end

   logic [MAX_SHIFT:0] shift_oh;
   logic [PHYS_W-1:0]  dram_addr;
   logic               hole_hit;
   logic [OUT_W-1:0]   sys_addr;

   xlat_ilv_decode #(
      .CODE_W    (CODE_W),
      .MAX_SHIFT (MAX_SHIFT)
   ) u_decode (
      .code     (ilv_code),
      .shift_oh (shift_oh)
   );

   xlat_ilv_insert #(
      .IN_W      (IN_W),
      .PHYS_W    (PHYS_W),
      .PAGE_LSB  (PAGE_LSB),
      .MAX_SHIFT (MAX_SHIFT)
   ) u_insert (
      .in_addr   (in_addr),
      .shift_oh  (shift_oh),
      .sel       (ilv_sel),
      .dram_addr (dram_addr)
   );

   xlat_hole_window #(
      .PHYS_W (PHYS_W)
   ) u_hole (
      .en        (hole_en),
      .dram_addr (dram_addr),
      .base      (hole_base),
      .size      (hole_size),
      .hit       (hole_hit)
   );

   xlat_sys_compose #(
      .PHYS_W (PHYS_W),
      .OUT_W  (OUT_W)
   ) u_compose (
      .dram_addr   (dram_addr),
      .hole_hit    (hole_hit),
      .hole_offset (hole_offset),
      .node_base   (node_base),
      .sys_addr    (sys_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_addr <= sys_addr;
      end
   end

endmodule

// File: rtl/xlat_rev_addr_chk.sv
module xlat_rev_addr_chk #(
   parameter int PHYS_W   = 40,
   parameter int OUT_W    = 64,
   parameter int PAGE_LSB = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [PAGE_LSB-1:0] in_low,
   input logic                hole_en,
   input logic                hole_hit,
   input logic [PAGE_LSB-1:0] dram_low,
   input logic                out_valid,
   input logic [OUT_W-1:0]    out_addr
);

   localparam int EXT_W = OUT_W - PHYS_W;

   p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_addr));

   p_hole_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !hole_en |-> !hole_hit);

   p_page_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (dram_low == in_low));

   if (EXT_W > 0) begin : g_canon
      p_canonical_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !hole_hit) |=>
            (out_addr[OUT_W-1:PHYS_W] == {EXT_W{out_addr[PHYS_W-1]}}));
   end

endmodule

bind xlat_rev_addr xlat_rev_addr_chk #(
   .PHYS_W   (PHYS_W),
   .OUT_W    (OUT_W),
   .PAGE_LSB (PAGE_LSB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_low    (in_addr[PAGE_LSB-1:0]),
   .hole_en   (hole_en),
   .hole_hit  (hole_hit),
   .dram_low  (dram_addr[PAGE_LSB-1:0]),
   .out_valid (out_valid),
   .out_addr  (out_addr)
);

// File: tb/xlat_rev_addr_test.sv
module xlat_rev_addr_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [35:0] in_addr = '0;
   logic [2:0]  ilv_code = '0;
   logic [2:0]  ilv_sel = '0;
   logic [39:0] node_base = '0;
   logic        hole_en = 1'b0;
   logic [39:0] hole_base = '0;
   logic [39:0] hole_size = '0;
   logic [39:0] hole_offset = '0;
   logic        out_valid;
   logic [63:0] out_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [63:0] q_exp [$];
   string       q_tag [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   xlat_rev_addr uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_addr     (in_addr),
      .ilv_code    (ilv_code),
      .ilv_sel     (ilv_sel),
      .node_base   (node_base),
      .hole_en     (hole_en),
      .hole_base   (hole_base),
      .hole_size   (hole_size),
      .hole_offset (hole_offset),
      .out_valid   (out_valid),
      .out_addr    (out_addr)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=0x%016h exp=0x%016h", tag, act, exp);
      end
   endtask

   // Change static configuration on an idle cycle.
   task automatic set_cfg(input logic [2:0] code, input logic [2:0] sel,
                          input logic [39:0] nb, input logic hen,
                          input logic [39:0] hb, input logic [39:0] hs,
                          input logic [39:0] ho);
      @(negedge clk);
      in_valid    = 1'b0;
      ilv_code    = code;
      ilv_sel     = sel;
      node_base   = nb;
      hole_en     = hen;
      hole_base   = hb;
      hole_size   = hs;
      hole_offset = ho;
   endtask

   // Driver: one request per call, expectation goes to the scoreboard.
   task automatic drive(input logic [35:0] a, input logic [63:0] exp,
                        input string tag);
      @(negedge clk);
      in_addr  = a;
      in_valid = 1'b1;
      q_exp.push_back(exp);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Monitor: compares each result against the oldest expectation.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_exp.size() == 0) begin
            check(1'b0, "R8 result with no request", out_addr, 64'h0);
         end else begin
            logic [63:0] e;
            string       t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(out_addr === e, t, out_addr, e);
         end
      end
   end

   function automatic int shift_for(input logic [2:0] code);
      case (code)
         3'd1:    return 1;
         3'd3:    return 2;
         3'd7:    return 3;
         default: return 0;
      endcase
   endfunction

   // Forward model: DRAM address to controller input address.
   function automatic logic [35:0] strip(input logic [63:0] dram, input int sh);
      logic [63:0] v;
      v = ((dram >> sh) & 64'hF_FFFF_F000) | (dram & 64'hFFF);
      return v[35:0];
   endfunction

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R8 watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] r;
      logic [63:0] sys;
      logic [63:0] dram;
      int          sh;

      // R9: reset state
      repeat (3) @(negedge clk);
      in_valid = 1'b1;
      in_addr  = 36'h123;
      @(negedge clk);
      check(out_valid == 1'b0, "R9 out_valid in reset", 64'(out_valid), 64'h0);
      check(out_addr == 64'h0, "R9 out_addr in reset", out_addr, 64'h0);
      in_valid = 1'b0;
      rst_n    = 1'b1;

      // R2, R1: shift 0 codes pass the address and ignore the select value
      set_cfg(3'd0, 3'd5, 40'h0, 1'b0, 40'h0, 40'h0, 40'h0);
      drive(36'h1_2345_6789, 64'h1_2345_6789, "R2 code0 passthrough");
      set_cfg(3'd2, 3'd7, 40'h0, 1'b0, 40'h0, 40'h0, 40'h0);
      drive(36'h0_ABCD_E123, 64'h0_ABCD_E123, "R1 code2 acts as shift0");
      set_cfg(3'd4, 3'd3, 40'h0, 1'b0, 40'h0, 40'h0, 40'h0);
      drive(36'h0_0000_5FFF, 64'h0_0000_5FFF, "R1 code4 acts as shift0");
      set_cfg(3'd5, 3'd1, 40'h0, 1'b0, 40'h0, 40'h0, 40'h0);
      drive(36'h0_0001_0001, 64'h0_0001_0001, "R1 code5 acts as shift0");
      set_cfg(3'd6, 3'd6, 40'h0, 1'b0, 40'h0, 40'h0, 40'h0);
      drive(36'h0_0002_0002, 64'h0_0002_0002, "R1 code6 acts as shift0");

      // R3: shift 1, select 1
      set_cfg(3'd1, 3'd1, 40'h0, 1'b0, 40'h0, 40'h0, 40'h0);
      drive(36'h0_0000_3ABC, 64'h0_0000_7ABC, "R3 shift1 insert");
      // R4: shift 2, select 7 masked to 3
      set_cfg(3'd3, 3'd7, 40'h0, 1'b0, 40'h0, 40'h0, 40'h0);
      drive(36'h0_0001_2345, 64'h0_0004_B345, "R4 select masked to 2 bits");
      // R4: shift 1, select 6 masked to 0
      set_cfg(3'd1, 3'd6, 40'h0, 1'b0, 40'h0, 40'h0, 40'h0);
      drive(36'h0_0000_1001, 64'h0_0000_2001, "R4 select masked to 1 bit");
      // R3: shift 3, full-width frame
      set_cfg(3'd7, 3'd5, 40'h0, 1'b0, 40'h0, 40'h0, 40'h0);
      drive(36'hF_FFFF_F001, 64'h7F_FFFF_D001, "R3 shift3 top frame");

      // R7: sign extension and 40-bit wrap in the base path
      set_cfg(3'd0, 3'd0, 40'hFF_0000_0000, 1'b0, 40'h0, 40'h0, 40'h0);
      drive(36'h0_0000_1000, 64'hFFFF_FFFF_0000_1000, "R7 bit39 set extends");
      set_cfg(3'd0, 3'd0, 40'hFF_FFFF_F000, 1'b0, 40'h0, 40'h0, 40'h0);
      drive(36'h0_0000_2000, 64'h0000_0000_0000_1000, "R7 base sum wraps at 40 bits");

      // R5, R6: hole window
      set_cfg(3'd0, 3'd0, 40'h2_0000_0000, 1'b1, 40'hC000_0000, 40'h4000_0000,
              40'h4000_0000);
      drive(36'h0_C000_0010, 64'h1_0000_0010, "R5 hole remap");
      drive(36'h0_FFFF_FFFF, 64'h1_3FFF_FFFF, "R6 last hole address");
      drive(36'h1_0000_0000, 64'h3_0000_0000, "R6 hole upper bound excluded");
      drive(36'h0_BFFF_FFFF, 64'h2_BFFF_FFFF, "R6 just below hole base");
      set_cfg(3'd0, 3'd0, 40'h2_0000_0000, 1'b0, 40'hC000_0000, 40'h4000_0000,
              40'h4000_0000);
      drive(36'h0_C000_0010, 64'h2_C000_0010, "R6 hole disabled");
      set_cfg(3'd0, 3'd0, 40'h0, 1'b1, 40'hC000_0000, 40'h4000_0000,
              40'hF0_0000_0000);
      drive(36'h0_C000_0000, 64'h0000_00F0_C000_0000, "R5 hole path not extended");

      // R8: outputs hold while idle
      idle(2);
      begin
         logic [63:0] held;
         held = out_addr;
         @(negedge clk);
         in_addr  = 36'h5_5555_5555;
         ilv_code = 3'd7;
         idle(3);
         check(out_valid == 1'b0, "R8 no valid while idle", 64'(out_valid), 64'h0);
         check(out_addr == held, "R8 address held while idle", out_addr, held);
      end

      // R3, R7: round trip through the forward model, base path, shift 2
      set_cfg(3'd3, 3'd2, 40'h10_0000_0000, 1'b0, 40'h0, 40'h0, 40'h0);
      sh = shift_for(3'd3);
      r  = 64'h0123_4567_89AB_CDEF;
      for (int i = 0; i < 16; i++) begin
         r    = r * 64'd6364136223846793005 + 64'd1442695040888963407;
         dram = (64'(r[35:12]) << (12 + sh)) | (64'd2 << 12) | 64'(r[11:0]);
         sys  = dram + 64'h10_0000_0000;
         drive(strip(sys - 64'h10_0000_0000, sh), sys, "R3 round trip node range");
      end

      // R5: round trip through the forward model inside the hole, shift 0
      set_cfg(3'd0, 3'd0, 40'h2_0000_0000, 1'b1, 40'hC000_0000, 40'h4000_0000,
              40'h4000_0000);
      for (int i = 0; i < 12; i++) begin
         r   = r * 64'd6364136223846793005 + 64'd1442695040888963407;
         sys = 64'h1_0000_0000 + (r & 64'h3FFF_FFFF);
         drive(strip(sys - 64'h4000_0000, 0), sys, "R5 round trip hole window");
      end

      idle(4);
      check(q_exp.size() == 0, "R8 every request answered",
            64'(q_exp.size()), 64'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule